// File: doc/BRIEF.md
# Configurable Input Debounce Conditioner

This block cleans up one digital input before it reaches an event counter. The raw pin is first brought into the clock domain by a chain of synchronizer flops. It can then be inverted. After that it passes either straight through or through a debounce filter, and the result drives a counter input. The filter offers two behaviours. In settle mode the output moves only once the input has held its new level for a programmed number of clock cycles. In leading mode the first edge passes at once, and the output is then frozen until the input has been quiet for that many cycles.

The conditioned level is a registered output. Two single-cycle strobes mark its rising and falling transitions, and a third strobe, the count strobe, fires only on the transitions that the edge-select setting enables. During reset the filter loads the current synchronized level, so leaving reset never creates a false edge.

Top module: `din_conditioner`

## Requirements
- R1: The raw pin passes through SYNC_STAGES synchronizer flops (default 2). In direct (unfiltered) operation a pin change shows on `level_out` after the third rising clock edge.
- R2: With `cfg_invert` = 1 the conditioned level is the complement of the synchronized pin. With `cfg_invert` = 0 it is the same as the synchronized pin.
- R3: With `cfg_bypass` = 1 the filter is skipped and `cfg_time` has no effect: `level_out` equals the (optionally inverted) synchronized level of the previous cycle.
- R4: In settle mode (`cfg_mode` = 0) `level_out` takes a new level only after the polarity-adjusted input has differed from it on `cfg_time` consecutive clock edges. It changes on the last of those edges, so it lags a pin change by `cfg_time` + 2 edges.
- R5: In settle mode, an excursion that holds the other level for fewer than `cfg_time` consecutive edges leaves `level_out` unchanged and produces no strobe.
- R6: In leading mode (`cfg_mode` = 1), when the block is free, the first input level that differs from `level_out` is taken on the next edge, with the same latency as direct operation.
- R7: In leading mode, after each accepted edge, input changes are ignored until the input has kept one level for `cfg_time` consecutive edges. After that the next differing level is accepted.
- R8: `cfg_time` = 0 acts like bypass in both modes.
- R9: `rise_pulse` and `fall_pulse` are each high for exactly the one cycle in which `level_out` has just gone 0→1 or 1→0. `count_pulse` follows `cfg_edge`, where bit 0 enables rising transitions and bit 1 enables falling ones.
- R10: While `rst_n` is low, `level_out` loads the current polarity-adjusted synchronized level. No strobe is issued in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous input |
| cfg_invert | input | 1 | Invert the synchronized input |
| cfg_bypass | input | 1 | Skip the debounce filter |
| cfg_mode | input | 1 | 0 = settle mode, 1 = leading mode |
| cfg_time | input | TIME_W | Debounce time in clock cycles |
| cfg_edge | input | 2 | Count strobe enable: bit 0 rising, bit 1 falling |
| level_out | output | 1 | Conditioned level |
| rise_pulse | output | 1 | One-cycle strobe on a 0→1 change of level_out |
| fall_pulse | output | 1 | One-cycle strobe on a 1→0 change of level_out |
| count_pulse | output | 1 | One-cycle strobe on each enabled transition |

## Verification
The bench builds the block with TIME_W = 4 and the default two-stage synchronizer. This keeps the time field small enough to sweep every value from 0 to 15, including the largest, in both filter modes and both polarities. A per-cycle arithmetic model then compares every output on every cycle against pseudo-random bursts, some shorter and some longer than the programmed time. Directed cases pin down the latencies, the glitch rejection, the leading-mode hold window and the exit from reset.

// File: rtl/din_cond_pkg.sv
package din_cond_pkg;

   typedef enum logic {
      FILT_SETTLE  = 1'b0,
      FILT_LEADING = 1'b1
   } filt_mode_e;

   localparam int unsigned EDGE_SEL_W = 2;
   localparam int unsigned EDGE_RISE_BIT = 0;
   localparam int unsigned EDGE_FALL_BIT = 1;

endpackage

// File: rtl/dc_sync.sv
module dc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);

   initial begin
      if (STAGES < 2) $error("dc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      chain[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dc_filter.sv
module dc_filter
   import din_cond_pkg::*;
#(
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pol,
   input  logic              direct,
   input  filt_mode_e        mode,
   input  logic [TIME_W-1:0] dtime,
   output logic              level
);

   localparam logic [TIME_W-1:0] ONE = {{(TIME_W-1){1'b0}}, 1'b1};

   logic [TIME_W-1:0] cnt;
   logic [TIME_W-1:0] lim;
   logic              hold;
   logic              prv;

   assign lim = dtime - ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= pol;
         prv   <= pol;
         hold  <= 1'b0;
         cnt   <= '0;
      end else begin
         prv <= pol;
         if (direct) begin
            level <= pol;
            hold  <= 1'b0;
            cnt   <= '0;
         end else if (mode == FILT_SETTLE) begin
            hold <= 1'b0;
            if (pol == level) begin
               cnt <= '0;
            end else if (cnt == lim) begin
               level <= pol;
               cnt   <= '0;
            end else begin
               cnt <= cnt + ONE;
            end
         end else begin
            if (hold) begin
               if (pol != prv) begin
                  cnt <= '0;
               end else if (cnt == lim) begin
                  hold <= 1'b0;
                  cnt  <= '0;
               end else begin
                  cnt <= cnt + ONE;
               end
            end else if (pol != level) begin
               level <= pol;
               hold  <= 1'b1;
               cnt   <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/dc_edges.sv
module dc_edges
   import din_cond_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  seed,
   input  logic                  level,
   input  logic [EDGE_SEL_W-1:0] sel,
   output logic                  rise,
   output logic                  fall,
   output logic                  count
);

   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= seed;
      else        prev <= level;
   end

   assign rise  = rst_n & level & ~prev;
   assign fall  = rst_n & ~level & prev;
   assign count = (rise & sel[EDGE_RISE_BIT]) | (fall & sel[EDGE_FALL_BIT]);

endmodule

// File: rtl/din_conditioner.sv
module din_conditioner
   import din_cond_pkg::*;
#(
   parameter int unsigned TIME_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pin_in,
   input  logic                  cfg_invert,
   input  logic                  cfg_bypass,
   input  logic                  cfg_mode,
   input  logic [TIME_W-1:0]     cfg_time,
   input  logic [EDGE_SEL_W-1:0] cfg_edge,
   output logic                  level_out,
   output logic                  rise_pulse,
   output logic                  fall_pulse,
   output logic                  count_pulse
);

   initial begin
      if (TIME_W < 1 || TIME_W > 32) $error("din_conditioner: TIME_W out of range");
   end

   logic synced;
   logic pol;
   logic direct;

   dc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pin_in),
      .q   (synced)
   );

   assign pol    = synced ^ cfg_invert;
   assign direct = cfg_bypass | (cfg_time == '0);

   dc_filter #(.TIME_W(TIME_W)) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .pol    (pol),
      .direct (direct),
      .mode   (filt_mode_e'(cfg_mode)),
      .dtime  (cfg_time),
      .level  (level_out)
   );

   dc_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (pol),
      .level (level_out),
      .sel   (cfg_edge),
      .rise  (rise_pulse),
      .fall  (fall_pulse),
      .count (count_pulse)
   );

endmodule

// File: rtl/din_conditioner_chk.sv
module din_conditioner_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_bypass,
   input logic pol,
   input logic level_out,
   input logic rise_pulse,
   input logic fall_pulse,
   input logic count_pulse
);

   assert_change_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out != $past(level_out)) |-> (level_out == $past(pol)));

   assert_bypass_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_bypass) |-> (level_out == $past(pol)));

   assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pulse && fall_pulse));

   assert_rise_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |-> (level_out && !$past(level_out)));

   assert_fall_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pulse |-> (!level_out && $past(level_out)));

   assert_count_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      count_pulse |-> (rise_pulse || fall_pulse));

   assert_clean_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rise_pulse && !fall_pulse));

endmodule

bind din_conditioner din_conditioner_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_bypass  (cfg_bypass),
   .pol         (pol),
   .level_out   (level_out),
   .rise_pulse  (rise_pulse),
   .fall_pulse  (fall_pulse),
   .count_pulse (count_pulse)
);

// File: tb/tb_din_conditioner.sv
module tb_din_conditioner;

   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin = 1'b0;
   logic          inv = 1'b0;
   logic          byp = 1'b0;
   logic          mode = 1'b0;
   logic [TW-1:0] dtime = '0;
   logic [1:0]    esel = 2'b11;
   logic          level_out, rise_pulse, fall_pulse, count_pulse;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   din_conditioner #(.TIME_W(TW), .SYNC_STAGES(2)) dut (
      .clk (clk), .rst_n (rst_n), .pin_in (pin), .cfg_invert (inv),
      .cfg_bypass (byp), .cfg_mode (mode), .cfg_time (dtime), .cfg_edge (esel),
      .level_out (level_out), .rise_pulse (rise_pulse),
      .fall_pulse (fall_pulse), .count_pulse (count_pulse)
   );

   // reference model: two-sample delay line, then run-length rules
   logic m_d1 = 1'b0, m_d2 = 1'b0;
   logic m_out = 1'b0, m_last = 1'b0, m_prev = 1'b0, m_hold = 1'b0;
   int   m_run = 0, m_quiet = 0;

   always @(posedge clk) begin
      logic p;
      p = m_d2 ^ inv;
      m_last = m_out;
      if (!rst_n) begin
         m_out = p; m_last = p; m_hold = 1'b0; m_run = 0; m_quiet = 0;
      end else if (byp || dtime == 0) begin
         m_out = p; m_hold = 1'b0; m_run = 0; m_quiet = 0;
      end else if (!mode) begin
         if (p != m_out) m_run = m_run + 1; else m_run = 0;
         if (m_run >= int'(dtime)) begin m_out = p; m_run = 0; end
      end else if (m_hold) begin
         if (p == m_prev) begin
            m_quiet = m_quiet + 1;
            if (m_quiet >= int'(dtime)) begin m_hold = 1'b0; m_quiet = 0; end
         end else m_quiet = 0;
      end else if (p != m_out) begin
         m_out = p; m_hold = 1'b1; m_quiet = 0;
      end
      m_prev = p;
      m_d2 = m_d1;
      m_d1 = pin;
   end

   task automatic check_eq(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // edges counted until level_out reaches target
   task automatic latency(input logic target, output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (level_out !== target && k < 40);
   endtask

   initial begin
      #1_500_000;
      n_err++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int k;
      int pulses;
      logic [15:0] lfsr;

      // R10: exit from reset with pin high, no strobes
      pin = 1'b1; byp = 1'b0; mode = 1'b0; dtime = 9; esel = 2'b11;
      do_reset();
      @(negedge clk);
      check_eq(level_out, 1'b1, "R10 level after reset");
      check_eq(rise_pulse | fall_pulse | count_pulse, 1'b0, "R10 strobes after reset");

      // R1: direct latency of three edges
      byp = 1'b1; pin = 1'b0;
      repeat (5) @(negedge clk);
      pin = 1'b1;
      latency(1'b1, k);
      check_eq(k == 3, 1'b1, "R1 latency==3");

      // R2: inversion
      inv = 1'b1;
      repeat (4) @(negedge clk);
      check_eq(level_out, 1'b0, "R2 inverted level");
      inv = 1'b0;

      // R5: short excursion rejected in settle mode
      byp = 1'b0; mode = 1'b0; dtime = 5; pin = 1'b0; esel = 2'b11;
      do_reset();
      repeat (3) @(negedge clk);
      pin = 1'b1;
      repeat (4) @(negedge clk);
      pin = 1'b0;
      pulses = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (count_pulse || level_out) pulses++;
      end
      check_eq(pulses == 0, 1'b1, "R5 glitch rejected");

      // R4: settle latency is time+2
      pin = 1'b1;
      latency(1'b1, k);
      check_eq(k == 7, 1'b1, "R4 settle latency==7");

      // R6/R7: leading mode first edge immediate, chatter held off
      mode = 1'b1; pin = 1'b0;
      do_reset();
      repeat (3) @(negedge clk);
      pin = 1'b1;
      pulses = 0;
      k = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (count_pulse) pulses++;
         if (level_out && k == 0) k = i;
         if (i <= 20 && (i % 2) == 0) pin = ~pin;
      end
      check_eq(k == 3, 1'b1, "R6 leading latency==3");
      check_eq(pulses == 1, 1'b1, "R7 single strobe during chatter");
      check_eq(level_out, 1'b1, "R7 final level");

      // R9: edge select only rising
      mode = 1'b0; byp = 1'b1; esel = 2'b01; pin = 1'b1;
      repeat (5) @(negedge clk);
      pin = 1'b0;
      pulses = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (count_pulse) pulses++;
      end
      check_eq(pulses == 0, 1'b1, "R9 falling masked");

      // sweep every time value, mode and polarity against the model
      lfsr = 16'hACE1;
      for (int md = 0; md < 2; md++) begin
         for (int t = 0; t < 16; t++) begin
            for (int iv = 0; iv < 2; iv++) begin
               int hold_left;
               int burst_left;
               string tag;
               mode = md[0]; dtime = t[TW-1:0]; inv = iv[0];
               byp = (t % 5 == 3) && iv == 1;
               esel = 2'((t + iv) % 4);
               tag = byp ? "R3" : (t == 0) ? "R8" : md == 0 ? "R4/R5" : "R6/R7";
               pin = lfsr[0];
               do_reset();
               hold_left = 0; burst_left = 0;
               for (int c = 0; c < 140; c++) begin
                  @(negedge clk);
                  check_eq(level_out, m_out, tag);
                  check_eq(rise_pulse, m_out & ~m_last, "R9 rise");
                  check_eq(fall_pulse, ~m_out & m_last, "R9 fall");
                  check_eq(count_pulse, (m_out & ~m_last & esel[0]) | (~m_out & m_last & esel[1]), "R9 count");
                  lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                  if (burst_left > 0) begin
                     pin = lfsr[3];
                     burst_left--;
                  end else if (hold_left > 0) begin
                     hold_left--;
                  end else if (lfsr[5]) begin
                     burst_left = 1 + (int'(lfsr[11:8]) % (t + 1));
                  end else begin
                     pin = ~pin;
                     hold_left = 1 + (int'(lfsr[12:7]) % (2 * t + 4));
                  end
               end
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule